// File: doc/BRIEF.md
# SDRAM Command Front End with Bank Tracking

This block is the device-side command front end of a four-bank single-data-rate SDRAM model. On every rising clock edge it samples the chip-select, the three active-low command strobes, the clock-enable, the two bank-select bits and a 12-bit address bus. It turns the sampled pattern into one-cycle strobes for each bank (activate, read, write and close) and into global strobes for refresh and mode-register load. It also holds the last activated row, the last accessed column and the auto-precharge request of that access.

Each bank's open or closed state is tracked. An access to a closed bank is refused and reported on an error output. Address bit 10 has two jobs. On a read or write it asks for the bank to close on its own a fixed burst length later. On a precharge it widens the close to every bank. A storage model or protocol checker uses the strobes and the bank state. The block holds no array, no data path and no refresh timers.

Top module: `sdram_cmd_front`

## Requirements
- R1: Command code {rasN,casN,weN} = 3'b011 with csN low is an activate. One edge after it is sampled, actStb pulses for the bank numbered bankSel, rowAddr holds all 12 address bits, and bankOpen for that bank is 1.
- R2: Codes 3'b101 (read) and 3'b100 (write) to an open bank pulse rdStb or wrStb for bankSel one edge after sampling. They load colAddr with address bits 9..0 and autoPre with address bit 10.
- R3: Code 3'b010 is a precharge. With address bit 10 low it closes only bank bankSel. With bit 10 high it closes all four banks, whatever bankSel holds. preStb pulses for every bank closed and bankOpen clears.
- R4: A read or write accepted with address bit 10 high closes its bank exactly BURST_LEN enabled edges after the access was sampled (4 by default). At that edge preStb pulses for the bank and bankOpen clears.
- R5: A read or write to a closed bank pulses accessErr one edge after sampling. It gives no rdStb or wrStb and leaves colAddr, autoPre and bankOpen unchanged.
- R6: With csN high, no command is decoded. A pending auto-precharge countdown still runs and completes.
- R7: With cke low, the edge produces no strobe and no error, and all bank state and countdowns stay frozen.
- R8: Code 3'b001 pulses refStb and code 3'b000 pulses mrsStb one edge after sampling. Code 3'b111 produces no strobe.
- R9: If an activate to a bank is sampled on the edge where that bank's auto-precharge completes, preStb and actStb both pulse for it and the bank ends open.
- R10: After reset all strobes, accessErr and bankOpen are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| csN | input | 1 | Active-low command select |
| rasN | input | 1 | Command bit 2, active low |
| casN | input | 1 | Command bit 1, active low |
| weN | input | 1 | Command bit 0, active low |
| bankSel | input | 2 | Bank number |
| addr | input | 12 | Row, column and bit-10 control |
| actStb | output | 4 | Per-bank activate pulse |
| rdStb | output | 4 | Per-bank read pulse |
| wrStb | output | 4 | Per-bank write pulse |
| preStb | output | 4 | Per-bank close pulse, explicit or automatic |
| refStb | output | 1 | Refresh pulse |
| mrsStb | output | 1 | Mode-register load pulse |
| rowAddr | output | 12 | Row of the last activate |
| colAddr | output | 10 | Column of the last accepted access |
| autoPre | output | 1 | Auto-precharge request of the last accepted access |
| bankOpen | output | 4 | Open flag per bank |
| accessErr | output | 1 | Access to a closed bank |

## Verification
The collision of interest is an auto-precharge countdown ending on the same edge that a new command for the same bank is sampled. The bench writes to a bank with bit 10 high, idles for exactly the remaining count, then issues an activate to that bank on the final edge. It expects both a close pulse and an activate pulse, with the bank left open. Countdowns that run through deselected cycles and through clock-enable-low cycles are also checked, to confirm that the closing edge moves only with the enabled edges.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W = $clog2(NUM_BANKS);

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmdCode_t;

  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic preAll;
    logic refresh;
    logic modeSet;
    logic [NUM_BANKS-1:0] bankHot;
  } cmdStb_t;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int AP_BIT = 10,
  parameter int ADDR_W = 12
) (
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] addr,
  output cmdStb_t           stb
);
  cmdCode_t code;
  assign code = cmdCode_t'({rasN, casN, weN});

  always_comb begin
    stb = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      stb.bankHot[b] = (bankSel == BANK_W'(b));
    end
    if (cke && !csN) begin
      unique case (code)
        CMD_ACT: stb.act = 1'b1;
        CMD_RD:  stb.rd = 1'b1;
        CMD_WR:  stb.wr = 1'b1;
        CMD_PRE: begin
          stb.pre = 1'b1;
          stb.preAll = addr[AP_BIT];
        end
        CMD_REF: stb.refresh = 1'b1;
        CMD_MRS: stb.modeSet = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  parameter int AP_BIT = 10,
  parameter int BURST_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  cmdStb_t              stb,
  input  logic [ROW_W-1:0]     addr,
  output logic [NUM_BANKS-1:0] actStb,
  output logic [NUM_BANKS-1:0] rdStb,
  output logic [NUM_BANKS-1:0] wrStb,
  output logic [NUM_BANKS-1:0] preStb,
  output logic                 refStb,
  output logic                 mrsStb,
  output logic [ROW_W-1:0]     rowAddr,
  output logic [COL_W-1:0]     colAddr,
  output logic                 autoPre,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 accessErr
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  logic [NUM_BANKS-1:0] openQ, accHit, apFire, closeNow;
  logic                 isAccess, accValid;

  assign isAccess = stb.rd | stb.wr;
  assign accValid = isAccess & |(stb.bankHot & openQ);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] apCnt;
    assign accHit[b]   = accValid & stb.bankHot[b];
    assign apFire[b]   = cke & (apCnt == CNT_W'(1)) & ~accHit[b];
    assign closeNow[b] = apFire[b] | (stb.pre & (stb.preAll | stb.bankHot[b]));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        apCnt <= '0;
      end else if (cke) begin
        if (accHit[b]) begin
          apCnt <= addr[AP_BIT] ? CNT_W'(BURST_LEN) : '0;
        end else if ((stb.act & stb.bankHot[b]) | closeNow[b]) begin
          apCnt <= '0;
        end else if (apCnt != '0) begin
          apCnt <= apCnt - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openQ     <= '0;
      actStb    <= '0;
      rdStb     <= '0;
      wrStb     <= '0;
      preStb    <= '0;
      refStb    <= 1'b0;
      mrsStb    <= 1'b0;
      accessErr <= 1'b0;
      rowAddr   <= '0;
      colAddr   <= '0;
      autoPre   <= 1'b0;
    end else begin
      openQ     <= (openQ & ~closeNow) | (stb.act ? stb.bankHot : '0);
      actStb    <= stb.act ? stb.bankHot : '0;
      rdStb     <= (stb.rd & accValid) ? stb.bankHot : '0;
      wrStb     <= (stb.wr & accValid) ? stb.bankHot : '0;
      preStb    <= closeNow;
      refStb    <= stb.refresh;
      mrsStb    <= stb.modeSet;
      accessErr <= isAccess & ~accValid;
      if (stb.act) rowAddr <= addr;
      if (accValid) begin
        colAddr <= addr[COL_W-1:0];
        autoPre <= addr[AP_BIT];
      end
    end
  end

  assign bankOpen = openQ;
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_cmd_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  parameter int AP_BIT = 10,
  parameter int BURST_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [ROW_W-1:0]     addr,
  output logic [NUM_BANKS-1:0] actStb,
  output logic [NUM_BANKS-1:0] rdStb,
  output logic [NUM_BANKS-1:0] wrStb,
  output logic [NUM_BANKS-1:0] preStb,
  output logic                 refStb,
  output logic                 mrsStb,
  output logic [ROW_W-1:0]     rowAddr,
  output logic [COL_W-1:0]     colAddr,
  output logic                 autoPre,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 accessErr
);
  cmdStb_t cmdStb;

  sdram_cmd_decode #(.AP_BIT(AP_BIT), .ADDR_W(ROW_W)) i_decode (
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankSel(bankSel), .addr(addr), .stb(cmdStb)
  );

  sdram_bank_track #(
    .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .BURST_LEN(BURST_LEN)
  ) i_track (
    .clk(clk), .rstN(rstN), .cke(cke), .stb(cmdStb), .addr(addr),
    .actStb(actStb), .rdStb(rdStb), .wrStb(wrStb), .preStb(preStb),
    .refStb(refStb), .mrsStb(mrsStb), .rowAddr(rowAddr), .colAddr(colAddr),
    .autoPre(autoPre), .bankOpen(bankOpen), .accessErr(accessErr)
  );
endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk
  import sdram_cmd_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cke,
  input logic                 csN,
  input logic [NUM_BANKS-1:0] actStb,
  input logic [NUM_BANKS-1:0] rdStb,
  input logic [NUM_BANKS-1:0] wrStb,
  input logic [NUM_BANKS-1:0] preStb,
  input logic                 refStb,
  input logic                 mrsStb,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic                 accessErr
);
  a_r1_act_opens: assert property (@(posedge clk) disable iff (!rstN)
    (actStb != '0) |-> ((bankOpen & actStb) == actStb));
  a_r1_one_act: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(actStb));
  a_r2_access_open: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStb | wrStb) != '0) |-> (((rdStb | wrStb) & bankOpen) != '0));
  a_r2_one_access: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdStb | wrStb));
  a_r3_pre_closes: assert property (@(posedge clk) disable iff (!rstN)
    ((preStb & ~actStb) != '0) |-> ((bankOpen & preStb & ~actStb) == '0));
  a_r5_err_no_access: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> ((rdStb | wrStb) == '0));
  a_r6_cs_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> (actStb == '0 && rdStb == '0 && wrStb == '0 &&
                    !refStb && !mrsStb && !accessErr));
  a_r7_cke_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cke) |-> (actStb == '0 && rdStb == '0 && wrStb == '0 &&
                     preStb == '0 && !refStb && !mrsStb && !accessErr));
  a_r7_cke_state: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> $stable(bankOpen));
endmodule

bind sdram_cmd_front sdram_cmd_front_chk i_chk (
  .clk(clk), .rstN(rstN), .cke(cke), .csN(csN),
  .actStb(actStb), .rdStb(rdStb), .wrStb(wrStb), .preStb(preStb),
  .refStb(refStb), .mrsStb(mrsStb), .bankOpen(bankOpen), .accessErr(accessErr)
);

// File: tb/test_sdram_cmd_front.sv
module test_sdram_cmd_front;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] bankSel = '0;
  logic [11:0] addr = '0;
  logic [3:0] actStb, rdStb, wrStb, preStb, bankOpen;
  logic refStb, mrsStb, autoPre, accessErr;
  logic [11:0] rowAddr;
  logic [9:0] colAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_front #(.BURST_LEN(BL)) i_sdram_cmd_front (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankSel(bankSel), .addr(addr), .actStb(actStb), .rdStb(rdStb),
    .wrStb(wrStb), .preStb(preStb), .refStb(refStb), .mrsStb(mrsStb),
    .rowAddr(rowAddr), .colAddr(colAddr), .autoPre(autoPre),
    .bankOpen(bankOpen), .accessErr(accessErr)
  );

  typedef struct {
    logic [3:0] act, rd, wr, pre, open;
    logic ref_, mrs, err, ap;
    logic [11:0] row;
    logic [9:0] col;
    string tag;
  } exp_t;

  exp_t q[$];
  bit [3:0] mOpen = '0;
  int mCnt[4] = '{0, 0, 0, 0};
  logic [11:0] mRow = '0;
  logic [9:0] mCol = '0;
  logic mAp = 1'b0;

  localparam bit [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010,
                       REF = 3'b001, MRS = 3'b000, NOP = 3'b111;

  task automatic issue(input bit ck, input bit cs, input bit [2:0] c,
                       input int bs, input bit [11:0] a, input string tag);
    exp_t e;
    bit dec, isAct, isRd, isWr, isPre, valid, fire, close;
    @(negedge clk);
    cke = ck; csN = cs; {rasN, casN, weN} = c; bankSel = 2'(bs); addr = a;
    @(posedge clk);
    dec = ck && !cs;
    isAct = dec && c == ACT; isRd = dec && c == RD;
    isWr = dec && c == WR; isPre = dec && c == PRE;
    valid = (isRd || isWr) && mOpen[bs];
    e.tag = tag;
    e.err = (isRd || isWr) && !mOpen[bs];
    e.ref_ = dec && c == REF;
    e.mrs = dec && c == MRS;
    e.act = isAct ? 4'(1 << bs) : 4'b0;
    e.rd = (isRd && valid) ? 4'(1 << bs) : 4'b0;
    e.wr = (isWr && valid) ? 4'(1 << bs) : 4'b0;
    if (isAct) mRow = a;
    if (valid) begin mCol = a[9:0]; mAp = a[10]; end
    for (int b = 0; b < 4; b++) begin
      fire = ck && mCnt[b] == 1 && !(valid && b == bs);
      close = fire || (isPre && (a[10] || b == bs));
      e.pre[b] = close;
      if (ck) begin
        if (valid && b == bs) mCnt[b] = a[10] ? BL : 0;
        else if ((isAct && b == bs) || close) mCnt[b] = 0;
        else if (mCnt[b] > 0) mCnt[b]--;
      end
      if (close) mOpen[b] = 1'b0;
      if (isAct && b == bs) mOpen[b] = 1'b1;
    end
    e.open = mOpen; e.row = mRow; e.col = mCol; e.ap = mAp;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(1, 0, NOP, 0, 12'h000, tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (actStb !== e.act || rdStb !== e.rd || wrStb !== e.wr ||
          preStb !== e.pre || refStb !== e.ref_ || mrsStb !== e.mrs ||
          accessErr !== e.err || bankOpen !== e.open || rowAddr !== e.row ||
          colAddr !== e.col || autoPre !== e.ap) begin
        errors++;
        $display("FAIL %s: act/rd/wr/pre=%h/%h/%h/%h ref=%b mrs=%b err=%b open=%h row=%h col=%h ap=%b expected %h/%h/%h/%h ref=%b mrs=%b err=%b open=%h row=%h col=%h ap=%b",
                 e.tag, actStb, rdStb, wrStb, preStb, refStb, mrsStb, accessErr,
                 bankOpen, rowAddr, colAddr, autoPre, e.act, e.rd, e.wr, e.pre,
                 e.ref_, e.mrs, e.err, e.open, e.row, e.col, e.ap);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checks++;
    if ({actStb, rdStb, wrStb, preStb, bankOpen} !== '0 || refStb || mrsStb || accessErr) begin
      errors++;
      $display("FAIL R10: strobes/open=%h expected 0",
               {actStb, rdStb, wrStb, preStb, bankOpen});
    end
    // R1 activates and row capture
    issue(1, 0, ACT, 0, 12'hABC, "R1 act bank0");
    issue(1, 0, ACT, 2, 12'h123, "R1 act bank2");
    // R2 read without auto-precharge, write with it
    issue(1, 0, RD, 0, 12'h155, "R2 read bank0");
    issue(1, 0, WR, 2, 12'h7FF, "R2 write bank2 ap");
    idle(BL, "R4 auto-precharge bank2");
    // R5 access to closed banks
    issue(1, 0, RD, 1, 12'h0AA, "R5 read closed bank1");
    issue(1, 0, WR, 2, 12'h011, "R5 write closed bank2");
    // R3 single and all-bank precharge
    issue(1, 0, PRE, 0, 12'h000, "R3 precharge bank0");
    issue(1, 0, ACT, 1, 12'hFFF, "R1 act bank1");
    issue(1, 0, ACT, 3, 12'h800, "R1 act bank3");
    issue(1, 0, PRE, 0, 12'h400, "R3 precharge all");
    // R8 refresh, mode set, no-op
    issue(1, 0, REF, 0, 12'h000, "R8 refresh");
    issue(1, 0, MRS, 0, 12'h033, "R8 mode set");
    issue(1, 0, NOP, 3, 12'hFFF, "R8 no-op");
    // R6 deselected commands ignored, countdown continues
    issue(1, 1, ACT, 1, 12'h555, "R6 deselected act");
    issue(1, 0, ACT, 0, 12'h246, "R6 act bank0");
    issue(1, 0, RD, 0, 12'h4C3, "R6 read bank0 ap");
    for (int i = 0; i < BL; i++) issue(1, 1, PRE, 0, 12'h400, "R6 countdown while deselected");
    // R7 clock enable low
    issue(0, 0, ACT, 1, 12'h777, "R7 act with cke low");
    issue(1, 0, ACT, 1, 12'h321, "R7 act bank1");
    issue(1, 0, RD, 1, 12'h40F, "R7 read bank1 ap");
    issue(1, 0, NOP, 0, 12'h000, "R7 count 1");
    for (int i = 0; i < 3; i++) issue(0, 0, PRE, 1, 12'h400, "R7 frozen");
    idle(BL - 1, "R7 resume countdown");
    // R9 collision of auto-precharge completion and activate
    issue(1, 0, ACT, 3, 12'h111, "R9 act bank3");
    issue(1, 0, WR, 3, 12'h422, "R9 write bank3 ap");
    idle(BL - 1, "R9 wait");
    issue(1, 0, ACT, 3, 12'h0F0, "R9 act on closing edge");
    issue(1, 0, RD, 3, 12'h00C, "R9 bank3 still open");
    idle(2, "R9 drain");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule